// File: doc/BRIEF.md
# Variable Integration Clock Generator

This block sets how long each sensor pixel integrates charge. Signal gain comes from the length of that integration window, so the block needs no amplifier stage. A 3-bit gain code picks how many bursts of 16 main-clock cycles make up one window. When a start request is accepted, the block raises a gated integration enable for exactly that many cycles. It then gives a single-cycle hold strobe that tells the pixel to keep its result. A third output goes low for as long as the generator is busy, which covers both the window and the hold cycle. The pipelined row/column scanner uses this output to decide when it may advance.

All three outputs are decoded from one small state register, and a down-counter that is loaded at the start of each window marks where the window ends. The gain code is read only on the cycle that accepts a start. A code of zero turns the generator off. The intended main clock is about 10 MHz, so the longest window of 112 cycles lasts roughly 11.2 µs per pixel.

Top module: `ivc_gen`

## Requirements
- R1: For a gain code g in 1..7, `integ_gate` is high for exactly g×16 consecutive main-clock cycles per accepted start.
- R2: Gain code 7 gives the longest window, 112 cycles of `integ_gate`.
- R3: A start request with gain code 0 has no effect: `integ_gate` and `hold_pulse` stay low and `hold_busy_n` stays high.
- R4: A start request during a window or during the hold cycle is ignored: the window runs to its full length and does not restart.
- R5: The gain code is sampled only on the cycle in which a start is accepted; changing it in the middle of a window does not change that window's length.
- R6: `integ_gate` goes high in the first cycle after the clock edge at which a start with a nonzero code is sampled while the block is idle.
- R7: `hold_pulse` is high for exactly one cycle, the cycle right after the last `integ_gate` cycle.
- R8: `hold_busy_n` is low whenever `integ_gate` or `hold_pulse` is high, and high when the generator is idle.
- R9: While `rst_n` is low at a clock edge, the block returns to idle after that edge: `integ_gate`=0, `hold_pulse`=0 and `hold_busy_n`=1, even if a window was running.
- R10: If start is held high, a new window begins two cycles after the hold cycle. Exactly one idle cycle lies between the hold strobe and the next `integ_gate` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin an integration window; sampled while idle |
| gain_code | input | 3 | Number of 16-cycle bursts per window; 0 disables |
| integ_gate | output | 1 | Gated integration clock enable, high for each integration cycle |
| hold_pulse | output | 1 | One-cycle strobe after the window ends |
| hold_busy_n | output | 1 | Low while a window or hold cycle is active, high when idle |

## Verification
One cycle after the edge that samples a valid start, `integ_gate` must be high. It stays high for g×16 cycles. `hold_pulse` follows on the very next cycle, and the cycle after that is idle. `hold_busy_n` is decoded from the same state register, so it must agree with the other two outputs in every cycle. The bench changes inputs on the falling edge and reads outputs on the falling edge, so every expected value is tied to a known number of register stages. For each gain code it counts the gate run one cycle at a time and compares that count with the code times 16. It then checks the hold cycle and the idle cycle at their exact positions.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTEG = 2'd1,
    ST_HOLD  = 2'd2
  } ivc_state_e;

  // window length in main-clock cycles for a given gain code
  function automatic int unsigned window_cycles(input int unsigned code,
                                                input int unsigned burst);
    return code * burst;
  endfunction

endpackage

// File: rtl/ivc_counter.sv
module ivc_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             win_last
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (run && (remain != '0)) begin
      remain <= remain - 1'b1;
    end
  end

  assign win_last = run && (remain == '0);

endmodule

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
  import ivc_pkg::*;
#(
  parameter int PERIOD_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PERIOD_W-1:0] gain_code,
  input  logic                win_last,
  output logic                win_start,
  output ivc_state_e          state
);

  ivc_state_e state_nx;

  assign win_start = (state == ST_IDLE) && start && (gain_code != '0);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (win_start) state_nx = ST_INTEG;
      ST_INTEG: if (win_last)  state_nx = ST_HOLD;
      ST_HOLD:                 state_nx = ST_IDLE;
      default:                 state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/ivc_outs.sv
module ivc_outs
  import ivc_pkg::*;
(
  input  ivc_state_e state,
  output logic       integ_gate,
  output logic       hold_pulse,
  output logic       hold_busy_n
);

  assign integ_gate  = (state == ST_INTEG);
  assign hold_pulse  = (state == ST_HOLD);
  assign hold_busy_n = ~(integ_gate | hold_pulse);

endmodule

// File: rtl/ivc_gen.sv
module ivc_gen
  import ivc_pkg::*;
#(
  parameter int PERIOD_W  = 3,
  parameter int BURST_LEN = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PERIOD_W-1:0] gain_code,
  output logic                integ_gate,
  output logic                hold_pulse,
  output logic                hold_busy_n
);

  localparam int MAX_CODE = (1 << PERIOD_W) - 1;
  localparam int MAX_LEN  = MAX_CODE * BURST_LEN;
  localparam int CNT_W    = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

  ivc_state_e       state;
  logic             win_start;
  logic             win_last;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(window_cycles(32'(gain_code), 32'(BURST_LEN)) - 1);

  ivc_ctrl #(.PERIOD_W(PERIOD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .gain_code (gain_code),
    .win_last  (win_last),
    .win_start (win_start),
    .state     (state)
  );

  ivc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (win_start),
    .load_val (load_val),
    .run      (state == ST_INTEG),
    .win_last (win_last)
  );

  ivc_outs u_outs (
    .state       (state),
    .integ_gate  (integ_gate),
    .hold_pulse  (hold_pulse),
    .hold_busy_n (hold_busy_n)
  );

endmodule

// File: rtl/ivc_gen_chk.sv
module ivc_gen_chk #(
  parameter int PERIOD_W  = 3,
  parameter int BURST_LEN = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [PERIOD_W-1:0] gain_code,
  input logic                integ_gate,
  input logic                hold_pulse,
  input logic                hold_busy_n,
  input logic                win_start,
  input logic                win_last
);

  int   run_len;
  int   exp_len;
  logic was_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= 0;
      exp_len <= 0;
    end else if (win_start) begin
      run_len <= 0;
      exp_len <= int'(gain_code) * BURST_LEN;
    end else if (integ_gate) begin
      run_len <= run_len + 1;
    end
  end

  always_ff @(posedge clk) was_rst <= !rst_n;

  // R9: outputs idle right after any reset edge
  always @(negedge clk) begin
    if (was_rst) begin
      a_r9_reset_idle: assert (hold_busy_n && !integ_gate && !hold_pulse);
    end
  end

  // R1 / R5: window length equals latched code times burst
  a_r1_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |-> (run_len + 1 == exp_len));

  a_r3_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_busy_n && start && gain_code == '0) |=> hold_busy_n);

  a_r6_gate_rise: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> integ_gate);

  a_r7_hold_follows: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> hold_pulse);

  a_r7_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pulse |=> !hold_pulse);

  a_r7_hold_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pulse |-> $past(integ_gate));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({integ_gate, hold_pulse}));

  // R4: a running window keeps going until its last cycle
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_gate && !win_last) |=> (integ_gate && !win_start));

endmodule

bind ivc_gen ivc_gen_chk #(.PERIOD_W(PERIOD_W), .BURST_LEN(BURST_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .gain_code   (gain_code),
  .integ_gate  (integ_gate),
  .hold_pulse  (hold_pulse),
  .hold_busy_n (hold_busy_n),
  .win_start   (win_start),
  .win_last    (win_last)
);

// File: tb/tb_ivc_gen.sv
module tb_ivc_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] gain_code = 3'd0;
  logic       integ_gate, hold_pulse, hold_busy_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ivc_gen dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .gain_code   (gain_code),
    .integ_gate  (integ_gate),
    .hold_pulse  (hold_pulse),
    .hold_busy_n (hold_busy_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "gate idle", int'(integ_gate), 0);
    check(req, "hold idle", int'(hold_pulse), 0);
    check(req, "busy_n idle", int'(hold_busy_n), 1);
  endtask

  // present a start on one edge; return at the falling edge after it
  task automatic launch(input int code);
    @(negedge clk);
    start = 1'b1;
    gain_code = 3'(code);
    @(negedge clk);
    start = 1'b0;
  endtask

  // called on the falling edge of the first expected gate cycle
  task automatic observe(input int exp_len, input string req, input int mid_code);
    int len = 0;
    int busy_hi = 0;
    while (integ_gate && len < 200) begin
      if (hold_busy_n) busy_hi++;
      len++;
      if (len == 2 && mid_code >= 0) gain_code = 3'(mid_code);
      @(negedge clk);
    end
    check(req, "gate length", len, exp_len);
    check("R8", "busy_n high during window", busy_hi, 0);
    check("R7", "hold after last gate", int'(hold_pulse), (exp_len > 0) ? 1 : 0);
    check("R8", "busy_n in hold cycle", int'(hold_busy_n), (exp_len > 0) ? 0 : 1);
    @(negedge clk);
    check("R7", "hold lasts one cycle", int'(hold_pulse), 0);
    check("R8", "busy_n after hold", int'(hold_busy_n), 1);
    check("R7", "gate stays low after hold", int'(integ_gate), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R9");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R9");

    // R1 / R2 / R3 / R6: sweep every gain code
    for (int c = 0; c < 8; c++) begin
      launch(c);
      check("R6", "gate in first cycle", int'(integ_gate), (c != 0) ? 1 : 0);
      if (c == 0) begin
        check_idle("R3");
        @(negedge clk);
        check_idle("R3");
      end else if (c == 7) begin
        observe(112, "R2", -1);
      end else begin
        observe(c * 16, "R1", -1);
      end
    end

    // R5: code changes mid-window, in both directions
    launch(2);
    observe(32, "R5", 7);
    launch(6);
    observe(96, "R5", 1);
    gain_code = 3'd0;

    // R4 / R10: start held high through window and hold
    @(negedge clk);
    start = 1'b1;
    gain_code = 3'd3;
    @(negedge clk);
    check("R6", "gate after held start", int'(integ_gate), 1);
    observe(48, "R4", -1);
    @(negedge clk);
    check("R10", "next window after one idle cycle", int'(integ_gate), 1);
    start = 1'b0;
    observe(48, "R10", -1);

    // R9: reset in the middle of a window
    launch(7);
    repeat (5) @(negedge clk);
    check("R9", "window running before reset", int'(integ_gate), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R9");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R9");

    // fresh window after reset still full length
    launch(1);
    observe(16, "R1", -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule